// File: doc/BRIEF.md
# Randomized Shared-Memory Arbiter

This block sits between a group of cores and one shared data memory that also exposes a character-output device in its upper address region. Each core pushes requests into its own small queue. A request is a read, a write, an atomic test-and-set or a no-op, and it carries an address and write data. The block serves at most one request per service slot. A slot occurs on one cycle in every M. The queue served in a slot is picked pseudo-randomly, so the order in which cores reach the memory is deliberately not fair or fixed.

A reply goes back only to the core that issued the request. It travels through a per-core delay line of fixed depth, so every reply arrives a constant number of cycles after its service edge. Writes to the device region emit a character on an output port. An all-idle output combines the cores' halt flags with the queue state, so the surrounding system can decide when to stop.

Top module: `shmem_arbiter`

## Requirements
- R1: While reset is asserted and just after it is released, `rsp_valid`, `fifo_full`, `fifo_ovf`, `char_valid` and `tas_err` are 0, and every shared-memory word holds 0. A read of a word that was never written replies 0.
- R2: Request kinds are encoded on 2 bits per core: 0 = read, 1 = write, 2 = test-and-set, 3 = no-op. A core whose `req_valid` bit is high at a rising edge enqueues one request, provided its queue is not full.
- R3: A phase counter is 0 after reset and counts modulo M on every edge. A request is served only at an edge where the phase is 0, so the first edge after reset is a slot.
- R4: A 16-bit LFSR is seeded to 0xACE1 at reset and advances on every edge; its new bit 0 is the XOR of old bits 15, 13, 12 and 10, and the other bits shift up by one. At a slot, the core chosen is the LFSR value before that edge modulo N. If the chosen queue was empty before the edge, nothing is served.
- R5: A reply raises `rsp_valid` of the requesting core only, for exactly one cycle, starting after the edge that comes D-1 edges after the service edge.
- R6: Addresses below 0x1000000 select a memory word by their low log2(MEM_WORDS) bits. A read replies with the stored word.
- R7: A memory write stores the data and produces no reply.
- R8: A test-and-set on memory stores 1. It replies 1 when bit 0 of the old word was 0, and 0 otherwise.
- R9: A write at or above 0x1000000 raises `char_valid` for one cycle, starting right after the service edge, with `char_data` equal to the low byte of the data. It produces no reply and leaves memory unchanged.
- R10: A read at or above 0x1000000 replies with all ones (no input available).
- R11: A test-and-set at or above 0x1000000 sets the sticky `tas_err`. It gives no reply and changes no memory.
- R12: Each queue holds 8 requests, and `fifo_full` is high while 8 are held. A push arriving while the queue is full is dropped, even if the same edge pops the queue, and it sets the sticky `fifo_ovf` bit of that core.
- R13: A no-op request is dequeued when served. It has no effect and gives no reply.
- R14: `all_idle` is high exactly when every `core_halted` bit is high and every queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N | Per-core request strobe |
| req_addr | input | N*AW | Per-core request address, core k at bits k*AW upward |
| req_kind | input | N*2 | Per-core request kind (0 read, 1 write, 2 test-and-set, 3 no-op) |
| req_wdata | input | N*DW | Per-core write data |
| core_halted | input | N | Per-core halted flag |
| fifo_full | output | N | Queue holds 8 requests |
| fifo_ovf | output | N | Sticky: a push was dropped because the queue was full |
| rsp_valid | output | N | Per-core reply strobe |
| rsp_data | output | N*DW | Per-core reply value |
| char_valid | output | 1 | Character emitted this cycle |
| char_data | output | 8 | Emitted character |
| tas_err | output | 1 | Sticky: test-and-set hit the device region |
| all_idle | output | 1 | All cores halted and all queues empty |

## Verification
A request pushed before edge e can be served no earlier than edge e+1. Its reply appears after service edge s plus D-1 further edges, and a device character appears right after edge s. Queue flags change on the edge that accepts a push, while `all_idle` follows `core_halted` combinationally. The bench carries a lockstep model of phase, LFSR, queues, memory and delay lines, updated at each rising edge from the inputs it drove at the falling edge before. Every registered output is compared with this model at each falling edge, and `all_idle` is sampled one time step after a halt change. The directed scenarios wait for each reply at falling edges and check its value.

// File: rtl/shmem_arbiter.sv
module shmem_arbiter #(
  parameter int N = 4,
  parameter int M = 2,
  parameter int D = 4,
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MEM_WORDS = 64,
  parameter logic [31:0] DEV_BASE = 32'h0100_0000,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_valid,
  input  logic [N*AW-1:0] req_addr,
  input  logic [N*2-1:0]  req_kind,
  input  logic [N*DW-1:0] req_wdata,
  input  logic [N-1:0]    core_halted,
  output logic [N-1:0]    fifo_full,
  output logic [N-1:0]    fifo_ovf,
  output logic [N-1:0]    rsp_valid,
  output logic [N*DW-1:0] rsp_data,
  output logic            char_valid,
  output logic [7:0]      char_data,
  output logic            tas_err,
  output logic            all_idle
);
  localparam int PW  = DEPTH > 1 ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int MW  = MEM_WORDS > 1 ? $clog2(MEM_WORDS) : 1;
  localparam int SW  = N > 1 ? $clog2(N) : 1;
  localparam int MCW = M > 1 ? $clog2(M) : 1;
  localparam logic [CW-1:0]  FULLV = CW'(DEPTH);
  localparam logic [PW-1:0]  LASTP = PW'(DEPTH - 1);
  localparam logic [MCW-1:0] LASTPH = MCW'(M - 1);
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_TAS = 2'd2;

  logic [AW-1:0] f_addr [N][DEPTH];
  logic [1:0]    f_kind [N][DEPTH];
  logic [DW-1:0] f_wd   [N][DEPTH];
  logic [PW-1:0] rp [N];
  logic [PW-1:0] wp [N];
  logic [CW-1:0] cnt [N];
  logic [N-1:0]  push_v, pop_v;
  logic          busy;

  logic [DW-1:0]  mem [MEM_WORDS];
  logic [15:0]    lfsr, pick;
  logic [MCW-1:0] ph;
  logic [SW-1:0]  sel;
  logic           slot, svc, is_dev, rep_v;
  logic [AW-1:0]  h_addr;
  logic [1:0]     h_kind;
  logic [DW-1:0]  h_wd, old_v, rep_d;
  logic [MW-1:0]  idx;

  logic [D-1:0]   dv [N];
  logic [DW-1:0]  dd [N][D];

  assign pick   = lfsr % 16'(N);
  assign sel    = pick[SW-1:0];
  assign slot   = (ph == '0);
  assign h_addr = f_addr[sel][rp[sel]];
  assign h_kind = f_kind[sel][rp[sel]];
  assign h_wd   = f_wd[sel][rp[sel]];
  assign svc    = slot && (cnt[sel] != '0);
  assign is_dev = h_addr >= AW'(DEV_BASE);
  assign idx    = h_addr[MW-1:0];
  assign old_v  = mem[idx];
  assign rep_v  = svc && (h_kind == K_RD || (h_kind == K_TAS && !is_dev));
  assign rep_d  = (h_kind == K_RD) ? (is_dev ? '1 : old_v)
                                   : {{(DW-1){1'b0}}, ~old_v[0]};

  always_comb begin
    busy = 1'b0;
    for (int k = 0; k < N; k++) begin
      push_v[k]    = req_valid[k] && (cnt[k] != FULLV);
      pop_v[k]     = svc && (sel == SW'(k));
      fifo_full[k] = (cnt[k] == FULLV);
      busy         = busy | (cnt[k] != '0);
    end
  end
  assign all_idle = (&core_halted) && !busy;

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (push_v[k]) begin
        f_addr[k][wp[k]] <= req_addr[k*AW +: AW];
        f_kind[k][wp[k]] <= req_kind[k*2 +: 2];
        f_wd[k][wp[k]]   <= req_wdata[k*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        rp[k] <= '0;
        wp[k] <= '0;
        cnt[k] <= '0;
      end
      fifo_ovf <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (push_v[k]) wp[k] <= (wp[k] == LASTP) ? '0 : wp[k] + PW'(1);
        if (pop_v[k])  rp[k] <= (rp[k] == LASTP) ? '0 : rp[k] + PW'(1);
        cnt[k] <= cnt[k] + CW'(push_v[k]) - CW'(pop_v[k]);
        if (req_valid[k] && cnt[k] == FULLV) fifo_ovf[k] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
    end else if (svc && !is_dev) begin
      if (h_kind == K_WR)       mem[idx] <= h_wd;
      else if (h_kind == K_TAS) mem[idx] <= DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= SEED;
      ph <= '0;
      char_valid <= 1'b0;
      char_data <= '0;
      tas_err <= 1'b0;
      for (int k = 0; k < N; k++) begin
        dv[k] <= '0;
        for (int i = 0; i < D; i++) dd[k][i] <= '0;
      end
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ph <= (ph == LASTPH) ? '0 : ph + MCW'(1);
      char_valid <= svc && is_dev && (h_kind == K_WR);
      if (svc && is_dev && h_kind == K_WR) char_data <= h_wd[7:0];
      if (svc && is_dev && h_kind == K_TAS) tas_err <= 1'b1;
      for (int k = 0; k < N; k++) begin
        for (int i = D - 1; i > 0; i--) begin
          dv[k][i] <= dv[k][i-1];
          dd[k][i] <= dd[k][i-1];
        end
        dv[k][0] <= rep_v && (sel == SW'(k));
        dd[k][0] <= rep_d;
      end
    end
  end

  logic [N-1:0] st0;
  for (genvar k = 0; k < N; k++) begin : g_out
    assign rsp_valid[k] = dv[k][D-1];
    assign rsp_data[k*DW +: DW] = dd[k][D-1];
    assign st0[k] = dv[k][0];

    p_depth_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[k] <= FULLV);
  end

  p_one_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));
  p_slot_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|st0) |-> ($past(ph) == '0));
  p_char_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> ($past(ph) == '0));
  p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ovf & $past(fifo_ovf)) == $past(fifo_ovf));
  p_tas_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tas_err) |-> tas_err);
endmodule

// File: tb/test_shmem_arbiter.sv
module test_shmem_arbiter;
  localparam int NC = 4, MD = 2, DL = 4, FD = 8;
  localparam logic [31:0] DEV = 32'h0100_0000;

  typedef struct packed {logic [31:0] a; logic [1:0] k; logic [31:0] w;} req_t;

  logic clk = 0, rst_n = 0;
  logic [NC-1:0] rv = '0, halt = '0;
  logic [NC*32-1:0] ra = '0, rw = '0;
  logic [NC*2-1:0] rk = '0;
  logic [NC-1:0] fifo_full, fifo_ovf, rsp_valid;
  logic [NC*32-1:0] rsp_data;
  logic char_valid, tas_err, all_idle;
  logic [7:0] char_data;

  int checks = 0, errors = 0, nchar = 0;
  logic [7:0] last_char = 0;
  bit done = 0;

  always #2 clk = ~clk;

  shmem_arbiter #(.N(NC), .M(MD), .D(DL), .DEPTH(FD)) i_shmem_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_addr(ra), .req_kind(rk),
    .req_wdata(rw), .core_halted(halt), .fifo_full(fifo_full), .fifo_ovf(fifo_ovf),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .char_valid(char_valid),
    .char_data(char_data), .tas_err(tas_err), .all_idle(all_idle));

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // lockstep model built from R2..R13
  int mcnt;
  logic [15:0] ml;
  req_t mq [NC][$];
  logic [31:0] mmem [64];
  logic mdv [NC][DL];
  logic [31:0] mdd [NC][DL];
  logic mchar_v, mtas;
  logic [7:0] mchar;
  logic [NC-1:0] movf;

  always @(posedge clk) begin : mdl
    int sel;
    bit dev;
    bit fb [NC];
    req_t h;
    if (!rst_n) begin
      mcnt = 0; ml = 16'hACE1; mchar_v = 0; mchar = 0; mtas = 0; movf = '0;
      for (int k = 0; k < NC; k++) begin
        mq[k].delete();
        for (int i = 0; i < DL; i++) begin mdv[k][i] = 0; mdd[k][i] = 0; end
      end
      for (int i = 0; i < 64; i++) mmem[i] = 0;
    end else begin
      for (int k = 0; k < NC; k++) fb[k] = (mq[k].size() == FD);
      sel = int'(ml) % NC;
      for (int k = 0; k < NC; k++) begin
        for (int i = DL - 1; i > 0; i--) begin mdv[k][i] = mdv[k][i-1]; mdd[k][i] = mdd[k][i-1]; end
        mdv[k][0] = 0;
      end
      mchar_v = 0;
      if (mcnt == 0 && mq[sel].size() != 0) begin
        h = mq[sel].pop_front();
        dev = h.a >= DEV;
        case (h.k)
          2'd0: begin mdv[sel][0] = 1; mdd[sel][0] = dev ? 32'hFFFF_FFFF : mmem[h.a[5:0]]; end
          2'd1: if (dev) begin mchar_v = 1; mchar = h.w[7:0]; end else mmem[h.a[5:0]] = h.w;
          2'd2: if (dev) mtas = 1;
                else begin
                  mdv[sel][0] = 1; mdd[sel][0] = {31'b0, ~mmem[h.a[5:0]][0]};
                  mmem[h.a[5:0]] = 1;
                end
          default: ;
        endcase
      end
      for (int k = 0; k < NC; k++)
        if (rv[k]) begin
          if (fb[k]) movf[k] = 1;
          else mq[k].push_back('{ra[k*32 +: 32], rk[k*2 +: 2], rw[k*32 +: 32]});
        end
      mcnt = (mcnt + 1) % MD;
      ml = {ml[14:0], ml[15] ^ ml[13] ^ ml[12] ^ ml[10]};
    end
  end

  // per-cycle comparison: R3 slot timing, R4 selection, R5 latency
  always @(negedge clk) if (rst_n && !done) begin : cmp
    logic [NC-1:0] ev, ef;
    for (int k = 0; k < NC; k++) begin ev[k] = mdv[k][DL-1]; ef[k] = (mq[k].size() == FD); end
    chk(rsp_valid == ev, "R3/R5 reply strobe timing", 32'(rsp_valid), 32'(ev));
    for (int k = 0; k < NC; k++)
      if (ev[k]) chk(rsp_data[k*32 +: 32] == mdd[k][DL-1], "R4 reply data of selected core",
                     rsp_data[k*32 +: 32], mdd[k][DL-1]);
    chk(fifo_full == ef, "R12 full flags", 32'(fifo_full), 32'(ef));
    chk(fifo_ovf == movf, "R12 overflow flags", 32'(fifo_ovf), 32'(movf));
    chk(char_valid == mchar_v && (!mchar_v || char_data == mchar), "R9 char output",
        {23'b0, char_valid, char_data}, {23'b0, mchar_v, mchar});
    chk(tas_err == mtas, "R11 tas_err", 32'(tas_err), 32'(mtas));
    if (char_valid) begin nchar++; last_char = char_data; end
  end

  task automatic xact(int c, logic [1:0] kind, logic [31:0] addr, logic [31:0] wd,
                      bit exp_rsp, logic [31:0] exp, string tag);
    bit seen = 0;
    logic [31:0] got = 0;
    @(negedge clk);
    rv[c] = 1; rk[c*2 +: 2] = kind; ra[c*32 +: 32] = addr; rw[c*32 +: 32] = wd;
    @(negedge clk);
    rv[c] = 0;
    for (int i = 0; i < 300; i++) begin
      if (rsp_valid[c] && !seen) begin seen = 1; got = rsp_data[c*32 +: 32]; end
      if (seen && exp_rsp) break;
      @(negedge clk);
    end
    chk(seen == exp_rsp, {tag, " reply presence"}, 32'(seen), 32'(exp_rsp));
    if (exp_rsp) chk(got == exp, {tag, " reply value"}, got, exp);
  endtask

  task automatic t_reset;
    chk(rsp_valid == 0 && fifo_full == 0 && fifo_ovf == 0, "R1 reset flags",
        {rsp_valid, fifo_full, fifo_ovf}, 0);
    chk(!char_valid && !tas_err, "R1 reset char/tas", {char_valid, tas_err}, 0);
    xact(1, 2'd0, 32'd5, 0, 1, 0, "R1 unwritten word");
  endtask

  task automatic t_rw;
    xact(0, 2'd1, 32'd3, 32'h1234_5678, 0, 0, "R7 write no reply");
    xact(2, 2'd0, 32'd3, 0, 1, 32'h1234_5678, "R2 R6 read back");
    xact(1, 2'd0, 32'h43, 0, 1, 32'h1234_5678, "R6 low-bit aliasing");
    xact(3, 2'd0, 32'd9, 0, 1, 0, "R6 never written");
  endtask

  task automatic t_tas;
    xact(3, 2'd2, 32'd12, 0, 1, 1, "R8 first tas");
    xact(3, 2'd2, 32'd12, 0, 1, 0, "R8 second tas");
    xact(0, 2'd0, 32'd12, 0, 1, 1, "R8 tas stores 1");
    xact(0, 2'd1, 32'd13, 32'd2, 0, 0, "R7 write 2");
    xact(2, 2'd2, 32'd13, 0, 1, 1, "R8 bit0 clear");
  endtask

  task automatic t_dev;
    int n0;
    xact(0, 2'd1, 32'd0, 32'h77, 0, 0, "R7 seed word 0");
    n0 = nchar;
    xact(1, 2'd1, DEV, 32'h141, 0, 0, "R9 device write");
    chk(nchar == n0 + 1 && last_char == 8'h41, "R9 char emitted", {nchar - n0, 24'(last_char)}, {8'd1, 24'h41});
    xact(2, 2'd0, DEV + 5, 0, 1, 32'hFFFF_FFFF, "R10 device read");
    xact(3, 2'd2, DEV, 0, 0, 0, "R11 device tas");
    chk(tas_err == 1, "R11 tas_err set", 32'(tas_err), 1);
    xact(0, 2'd0, 32'd0, 0, 1, 32'h77, "R9 R11 memory untouched");
  endtask

  task automatic t_nop;
    xact(1, 2'd3, 32'd20, 32'd5, 0, 0, "R13 no-op");
    xact(1, 2'd0, 32'd20, 0, 1, 0, "R13 no effect");
  endtask

  task automatic drain;
    halt = '1;
    for (int i = 0; i < 2000 && !all_idle; i++) @(negedge clk);
    repeat (DL + 2) @(negedge clk);
  endtask

  task automatic t_fifo;
    halt = '0;
    @(negedge clk);
    rv = '1;
    for (int k = 0; k < NC; k++) begin rk[k*2 +: 2] = 2'd0; ra[k*32 +: 32] = 32'd3; end
    repeat (20) @(negedge clk);
    rv = '0;
    chk(fifo_ovf == '1, "R12 overflow on every core", 32'(fifo_ovf), 32'hF);
    drain();
    chk(fifo_full == 0, "R12 full clears after drain", 32'(fifo_full), 0);
  endtask

  task automatic t_idle;
    halt = '1; #1;
    chk(all_idle == 1, "R14 idle when halted and empty", 32'(all_idle), 1);
    @(negedge clk); halt = 4'b0111; #1;
    chk(all_idle == 0, "R14 one core running", 32'(all_idle), 0);
    @(negedge clk); halt = '1;
    rv[2] = 1; rk[5:4] = 2'd3; ra[95:64] = 32'd1;
    @(negedge clk); rv[2] = 0; #1;
    chk(all_idle == 0, "R14 queue not empty", 32'(all_idle), 0);
    drain(); #1;
    chk(all_idle == 1, "R14 idle after drain", 32'(all_idle), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rw();
    t_tas();
    t_dev();
    t_nop();
    t_idle();
    t_fifo();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule